// File: doc/BRIEF.md
# Redundant Non-Binary Successive-Approximation Controller

This block is the digital search engine of a successive-approximation converter with `RES_BITS` of resolution that spends more comparison steps than it has output bits. Instead of fixing one bit per step, it keeps a signed running reference code. Each step adds one weight from a small writable weight table to that code, or subtracts it. Because the weights shrink by roughly the golden ratio rather than by two, several decision sequences land on the same output level. A comparator decision that is wrong because of noise or an unsettled reference is then absorbed by the later steps.

A conversion begins with a `start` pulse while the controller is idle. The controller then drives the reference code on `dac_code` and waits for one `cmp_valid` strobe per step. The `cmp_above` input reports whether the held input is above the reference. After the last step it forms the corrected, clamped result and raises `done` for one cycle. Out of reset the table holds half of full scale followed by falling Fibonacci numbers. Another table and another step count can be loaded between conversions.

The state machine has three states. `ST_IDLE` waits for a start. `ST_CONV` waits for comparator strobes. `ST_DONE` presents the result for one cycle. The transitions are:
- idle-to-convert on `start`;
- convert-to-convert on a strobe that is not the last;
- convert-to-done on the strobe of the final step;
- done-to-idle unconditionally.

Top module: `fib_sar_ctrl`

## Requirements
- R1: A `start` pulse in `ST_IDLE` loads the reference with table entry 0, the first weight p(1). That value appears on `dac_code` in the next cycle.
- R2: Each non-final `cmp_valid` strobe changes the reference to reference + p(k+1) when `cmp_above` is 1, and to reference − p(k+1) when it is 0. Here k is the number of the step just compared.
- R3: On the final strobe the result is the reference if `cmp_above` is 1, and the reference minus 1 if it is 0. That value is clamped to 0..2^RES_BITS−1.
- R4: Exactly one strobe per programmed step is consumed. `done` rises after the strobe of the last step and stays high for exactly one cycle.
- R5: After reset, `done`, `result` and `dac_code` are 0, the step count is 7, and the table holds 16,8,5,3,2,1,1. With correct decisions, every input in 0..31 converts to its floor.
- R6: A single wrong decision at step k, with the input within that step's correctable margin of the reference, still yields the floor of the input.
- R7: In `ST_IDLE`, a write with `wt_we` stores `wt_data` as weight p(wt_addr+1), with entry 0 being the first weight. A write with `steps_we` sets the number of steps.
- R8: Writes to the weight table or to the step count that arrive outside `ST_IDLE` are ignored.
- R9: A step-count write of 0, or of more than `MAX_STEPS`, is ignored.
- R10: The reference is a two's-complement value of RES_BITS+2 bits, so it can go below zero (for example −1).
- R11: A `start` pulse while a conversion runs is ignored.
- R12: `cmp_valid` outside `ST_CONV` has no effect, and `result` changes only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (accepted in idle only) |
| cmp_valid | input | 1 | Strobe: comparator decision for the current step is valid |
| cmp_above | input | 1 | 1 when the held input is above the reference |
| dac_code | output | RES_BITS+2 | Signed reference code for the DAC |
| wt_we | input | 1 | Weight table write enable |
| wt_addr | input | $clog2(MAX_STEPS) | Table entry to write (entry i holds p(i+1)) |
| wt_data | input | RES_BITS | Weight value |
| steps_we | input | 1 | Step-count write enable |
| steps_val | input | $clog2(MAX_STEPS+1) | Number of comparison steps |
| done | output | 1 | One-cycle completion pulse |
| result | output | RES_BITS | Corrected, clamped conversion result |

## Verification
The bench attacks the corner cases that distinguish a redundant search from a binary one:
- **Injected wrong decisions.** A controller that ignored the weights' overlap would return a level one off.
- **Inputs below zero and above full scale.** A missing clamp would wrap the result.
- **A table whose reference dips to −1.** An unsigned reference path would jump to a large positive code.
- **Table and step-count writes and stray starts during a conversion.** Wrongly accepting them changes the number of strobes consumed and the result.
- **Out-of-range step counts and idle strobes.** Acting on them would alter the next conversion or the held result.

// File: rtl/fsar_pkg.sv
package fsar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DONE = 2'd2
    } fsar_state_e;

    // n-th Fibonacci number, F(0)=0, F(1)=1
    function automatic int fib(input int n);
        int a;
        int b;
        int t;
        a = 0;
        b = 1;
        for (int i = 0; i < n; i++) begin
            t = a + b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    // Reset content of table entry idx (entry idx holds weight p(idx+1))
    function automatic int default_weight(input int idx, input int res_bits,
                                          input int steps);
        if (idx == 0)
            return 1 << (res_bits - 1);
        else if (idx < steps)
            return fib(steps - idx);
        else
            return 0;
    endfunction

endpackage

// File: rtl/fsar_weight_table.sv
module fsar_weight_table #(
    parameter int RES_BITS  = 5,
    parameter int MAX_STEPS = 8,
    parameter int DEF_STEPS = 7,
    localparam int AW       = $clog2(MAX_STEPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [RES_BITS-1:0] wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [RES_BITS-1:0] rd_data,
    output logic [RES_BITS-1:0] first_w
);

    logic [RES_BITS-1:0] w_q [MAX_STEPS];

    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_slot
        localparam logic [RES_BITS-1:0] RST_W =
            RES_BITS'(fsar_pkg::default_weight(g, RES_BITS, DEF_STEPS));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                w_q[g] <= RST_W;
            else if (wr_en && (wr_addr == AW'(g)))
                w_q[g] <= wr_data;
        end
    end

    assign rd_data = w_q[rd_addr];
    assign first_w = w_q[0];

endmodule

// File: rtl/fsar_step_ctrl.sv
module fsar_step_ctrl #(
    parameter int MAX_STEPS = 8,
    parameter int DEF_STEPS = 7,
    localparam int AW       = $clog2(MAX_STEPS),
    localparam int SW       = $clog2(MAX_STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cmp_valid,
    input  logic          steps_we,
    input  logic [SW-1:0] steps_val,
    output logic          idle,
    output logic          busy,
    output logic          done,
    output logic          load_first,
    output logic          advance,
    output logic          finish,
    output logic [AW-1:0] next_addr,
    output logic [SW-1:0] step_limit
);
    import fsar_pkg::*;

    fsar_state_e   state_q, state_d;
    logic [AW-1:0] step_q;      // zero-based index of the step being compared
    logic [SW-1:0] limit_q;
    logic          last_step;
    logic          steps_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign last_step = ((SW'(step_q) + SW'(1)) == limit_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CONV;
            ST_CONV: if (cmp_valid && last_step) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle       = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        load_first = 1'b0;
        advance    = 1'b0;
        finish     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle       = 1'b1;
                load_first = start;
            end
            ST_CONV: begin
                busy    = 1'b1;
                advance = cmp_valid && !last_step;
                finish  = cmp_valid && last_step;
            end
            ST_DONE: done = 1'b1;
            default: idle = 1'b0;
        endcase
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            step_q <= '0;
        else if (load_first)
            step_q <= '0;
        else if (advance)
            step_q <= step_q + AW'(1);
    end

    assign steps_ok = (steps_val != '0) && (steps_val <= SW'(MAX_STEPS));

    // programmed step count, writable in idle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            limit_q <= SW'(DEF_STEPS);
        else if (idle && steps_we && steps_ok)
            limit_q <= steps_val;
    end

    assign next_addr  = step_q + AW'(1);
    assign step_limit = limit_q;

endmodule

// File: rtl/fsar_ref_path.sv
module fsar_ref_path #(
    parameter int RES_BITS = 5,
    localparam int REF_W   = RES_BITS + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_first,
    input  logic                advance,
    input  logic                finish,
    input  logic                cmp_above,
    input  logic [RES_BITS-1:0] first_w,
    input  logic [RES_BITS-1:0] next_w,
    output logic [REF_W-1:0]    ref_code,
    output logic [RES_BITS-1:0] result
);

    localparam logic [REF_W-1:0] TOP_LVL = REF_W'((1 << RES_BITS) - 1);

    logic signed [REF_W-1:0] ref_q;
    logic signed [REF_W-1:0] step_w;
    logic signed [REF_W-1:0] final_lvl;
    logic [RES_BITS-1:0]     clamped;
    logic [RES_BITS-1:0]     result_q;

    assign step_w = $signed({2'b00, next_w});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ref_q <= '0;
        else if (load_first)
            ref_q <= $signed({2'b00, first_w});
        else if (advance)
            ref_q <= cmp_above ? (ref_q + step_w) : (ref_q - step_w);
    end

    // last half-step correction: keep the level when above, drop one when below
    assign final_lvl = cmp_above ? ref_q : (ref_q - REF_W'(1));

    always_comb begin
        if (final_lvl[REF_W-1])
            clamped = '0;
        else if (final_lvl > TOP_LVL)
            clamped = TOP_LVL[RES_BITS-1:0];
        else
            clamped = final_lvl[RES_BITS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            result_q <= '0;
        else if (finish)
            result_q <= clamped;
    end

    assign ref_code = ref_q;
    assign result   = result_q;

endmodule

// File: rtl/fib_sar_ctrl.sv
module fib_sar_ctrl #(
    parameter int RES_BITS  = 5,
    parameter int MAX_STEPS = 8,
    parameter int DEF_STEPS = 7,
    localparam int REF_W    = RES_BITS + 2,
    localparam int AW       = $clog2(MAX_STEPS),
    localparam int SW       = $clog2(MAX_STEPS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cmp_valid,
    input  logic                cmp_above,
    output logic [REF_W-1:0]    dac_code,
    input  logic                wt_we,
    input  logic [AW-1:0]       wt_addr,
    input  logic [RES_BITS-1:0] wt_data,
    input  logic                steps_we,
    input  logic [SW-1:0]       steps_val,
    output logic                done,
    output logic [RES_BITS-1:0] result
);

    logic                idle;
    logic                busy;
    logic                load_first;
    logic                advance;
    logic                finish;
    logic [AW-1:0]       next_addr;
    logic [SW-1:0]       step_limit;
    logic [RES_BITS-1:0] first_w;
    logic [RES_BITS-1:0] next_w;

    fsar_step_ctrl #(
        .MAX_STEPS (MAX_STEPS),
        .DEF_STEPS (DEF_STEPS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmp_valid  (cmp_valid),
        .steps_we   (steps_we),
        .steps_val  (steps_val),
        .idle       (idle),
        .busy       (busy),
        .done       (done),
        .load_first (load_first),
        .advance    (advance),
        .finish     (finish),
        .next_addr  (next_addr),
        .step_limit (step_limit)
    );

    fsar_weight_table #(
        .RES_BITS  (RES_BITS),
        .MAX_STEPS (MAX_STEPS),
        .DEF_STEPS (DEF_STEPS)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wt_we && idle),
        .wr_addr (wt_addr),
        .wr_data (wt_data),
        .rd_addr (next_addr),
        .rd_data (next_w),
        .first_w (first_w)
    );

    fsar_ref_path #(
        .RES_BITS (RES_BITS)
    ) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_first (load_first),
        .advance    (advance),
        .finish     (finish),
        .cmp_above  (cmp_above),
        .first_w    (first_w),
        .next_w     (next_w),
        .ref_code   (dac_code),
        .result     (result)
    );

endmodule

// File: rtl/fsar_checker.sv
module fsar_checker #(
    parameter int RES_BITS  = 5,
    parameter int MAX_STEPS = 8,
    localparam int REF_W    = RES_BITS + 2,
    localparam int SW       = $clog2(MAX_STEPS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                cmp_valid,
    input logic                idle,
    input logic                busy,
    input logic                done,
    input logic                advance,
    input logic [RES_BITS-1:0] first_w,
    input logic [RES_BITS-1:0] next_w,
    input logic [REF_W-1:0]    dac_code,
    input logic [SW-1:0]       step_limit,
    input logic [RES_BITS-1:0] result
);

    logic [REF_W-1:0] w_ext;
    assign w_ext = {2'b00, next_w};

    a_r1_start_loads_first: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle) |=> (dac_code == {2'b00, $past(first_w)}));

    a_r2_ref_moves_by_weight: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> ((dac_code == $past(dac_code) + $past(w_ext)) ||
                     (dac_code == $past(dac_code) - $past(w_ext))));

    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(cmp_valid) && $past(busy)));

    a_r8_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(step_limit));

    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !cmp_valid) |=> $stable(dac_code));

    a_r12_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

bind fib_sar_ctrl fsar_checker #(
    .RES_BITS  (RES_BITS),
    .MAX_STEPS (MAX_STEPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmp_valid  (cmp_valid),
    .idle       (idle),
    .busy       (busy),
    .done       (done),
    .advance    (advance),
    .first_w    (first_w),
    .next_w     (next_w),
    .dac_code   (dac_code),
    .step_limit (step_limit),
    .result     (result)
);

// File: tb/fib_sar_ctrl_tb.sv
module fib_sar_ctrl_tb;

    localparam int RES_BITS  = 5;
    localparam int MAX_STEPS = 8;
    localparam int REF_W     = RES_BITS + 2;
    localparam int AW        = $clog2(MAX_STEPS);
    localparam int SW        = $clog2(MAX_STEPS + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                cmp_valid = 1'b0;
    logic                cmp_above = 1'b0;
    logic [REF_W-1:0]    dac_code;
    logic                wt_we = 1'b0;
    logic [AW-1:0]       wt_addr = '0;
    logic [RES_BITS-1:0] wt_data = '0;
    logic                steps_we = 1'b0;
    logic [SW-1:0]       steps_val = '0;
    logic                done;
    logic [RES_BITS-1:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int    exp_q[$];
    string tag_q[$];
    int    trace[16];
    int    min_ref;
    int    strobes;

    always #10 clk = ~clk;

    fib_sar_ctrl #(
        .RES_BITS  (RES_BITS),
        .MAX_STEPS (MAX_STEPS),
        .DEF_STEPS (7)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmp_valid (cmp_valid),
        .cmp_above (cmp_above),
        .dac_code  (dac_code),
        .wt_we     (wt_we),
        .wt_addr   (wt_addr),
        .wt_data   (wt_data),
        .steps_we  (steps_we),
        .steps_val (steps_val),
        .done      (done),
        .result    (result)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ideal(input int vin_x10);
        int f;
        if (vin_x10 < 0) return 0;
        f = vin_x10 / 10;
        if (f > (1 << RES_BITS) - 1) f = (1 << RES_BITS) - 1;
        return f;
    endfunction

    // scoreboard monitor
    bit prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done && done) check("R4 done width", 1, 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check("R12 unexpected done", 1, 0);
                end else begin
                    check(tag_q.pop_front(), int'(result), exp_q.pop_front());
                end
            end
            prev_done = done;
        end
    end

    // driver: one conversion with a modelled comparator
    task automatic convert(input int vin_x10, input int flip_step,
                           input int exp_steps, input string tag,
                           input bit mid_start, input bit mid_write);
        int ref_now;
        exp_q.push_back(ideal(vin_x10));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        strobes = 0;
        min_ref = 1000;
        while (1) begin
            ref_now = int'($signed(dac_code));
            if (strobes < 16) trace[strobes] = ref_now;
            if (ref_now < min_ref) min_ref = ref_now;
            cmp_above = ((vin_x10 > ref_now * 10) != (strobes + 1 == flip_step));
            cmp_valid = 1'b1;
            strobes++;
            @(negedge clk);
            cmp_valid = 1'b0;
            if (done) break;
            if (strobes == 2) begin
                if (mid_start) start = 1'b1;
                if (mid_write) begin
                    wt_we = 1'b1; wt_addr = AW'(1); wt_data = 5'd15;
                    steps_we = 1'b1; steps_val = SW'(3);
                end
            end
            @(negedge clk);
            start = 1'b0; wt_we = 1'b0; steps_we = 1'b0;
            if (strobes > 20) break;
        end
        check({tag, " R4 strobe count"}, strobes, exp_steps);
        @(negedge clk);
    endtask

    task automatic load_table(input int w[8], input int steps);
        for (int i = 0; i < 8; i++) begin
            wt_we = 1'b1; wt_addr = AW'(i); wt_data = RES_BITS'(w[i]);
            @(negedge clk);
        end
        wt_we = 1'b0;
        steps_we = 1'b1; steps_val = SW'(steps);
        @(negedge clk);
        steps_we = 1'b0;
    endtask

    initial begin
        int fresh_res;
        repeat (3) @(negedge clk);
        // R5 reset state
        check("R5 reset done", int'(done), 0);
        check("R5 reset result", int'(result), 0);
        check("R5 reset dac_code", int'(dac_code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: first reference after start
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R1 first reference", int'($signed(dac_code)), 16);
        // finish this run with correct decisions for input 7.3
        exp_q.push_back(7); tag_q.push_back("R5 vin 7.3 first run");
        for (int s = 0; s < 7; s++) begin
            cmp_above = (73 > int'($signed(dac_code)) * 10);
            cmp_valid = 1'b1;
            @(negedge clk);
            cmp_valid = 1'b0;
            if (s < 6) @(negedge clk);
        end
        @(negedge clk);

        // R2: trace of references for 7.3 with default table
        convert(73, 0, 7, "R5 vin 7.3", 0, 0);
        check("R2 ref step2", trace[1], 8);
        check("R2 ref step3", trace[2], 3);
        check("R2 ref step4", trace[3], 6);
        check("R2 ref step5", trace[4], 8);
        check("R2 ref step6", trace[5], 7);
        check("R2 ref step7", trace[6], 8);

        // R5: other inputs with correct decisions
        convert(126, 0, 7, "R5 vin 12.6", 0, 0);
        convert(5,   0, 7, "R5 vin 0.5", 0, 0);
        convert(315, 0, 7, "R5 vin 31.5", 0, 0);
        convert(204, 0, 7, "R5 vin 20.4", 0, 0);

        // R3: clamping below zero and above full scale
        convert(-5,  0, 7, "R3 vin -0.5 clamp low", 0, 0);
        convert(400, 0, 7, "R3 vin 40.0 clamp high", 0, 0);

        // R6: single wrong decisions inside the margin
        convert(73,  2, 7, "R6 vin 7.3 flip step 2", 0, 0);
        convert(126, 3, 7, "R6 vin 12.6 flip step 3", 0, 0);

        // R11 and R8: stray start and config writes mid-conversion
        convert(126, 0, 7, "R11 start mid conversion", 1, 0);
        convert(73,  0, 7, "R8 writes mid conversion", 0, 1);
        convert(204, 0, 7, "R8 table unchanged afterwards", 0, 0);

        // R12: strobes while idle change nothing
        fresh_res = int'(result);
        for (int i = 0; i < 4; i++) begin
            cmp_above = i[0]; cmp_valid = 1'b1;
            @(negedge clk);
            check("R12 idle strobe done", int'(done), 0);
            check("R12 idle strobe result", int'(result), fresh_res);
        end
        cmp_valid = 1'b0;
        @(negedge clk);
        convert(126, 0, 7, "R12 after idle strobes", 0, 0);

        // R7: load 16,10,6,3,2,1 with six steps
        load_table('{16, 10, 6, 3, 2, 1, 0, 0}, 6);
        convert(63, 0, 6, "R7 table 16,10,6,3,2,1", 0, 0);
        convert(63, 2, 6, "R6 R7 flip step 2", 0, 0);

        // R9: out-of-range step counts ignored
        steps_we = 1'b1; steps_val = SW'(0);
        @(negedge clk);
        steps_val = SW'(9);
        @(negedge clk);
        steps_we = 1'b0;
        convert(63, 0, 6, "R9 bad step counts", 0, 0);

        // R7: eight-step table 16,4,4,2,2,1,1,1
        load_table('{16, 4, 4, 2, 2, 1, 1, 1}, 8);
        convert(73,  0, 8, "R7 eight-step vin 7.3", 0, 0);
        convert(204, 0, 8, "R7 eight-step vin 20.4", 0, 0);

        // R10: table whose reference passes below zero
        load_table('{16, 8, 5, 4, 2, 1, 1, 0}, 7);
        convert(2, 0, 7, "R10 vin 0.2", 0, 0);
        check("R10 lowest reference", min_ref, -1);

        repeat (3) @(negedge clk);
        check("R4 all results seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule